// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the sequencing logic and the approximation register of a successive-approximation analog-to-digital converter. A start request begins a conversion. The block then runs a binary search over the output code, one bit per clock, beginning at the most significant bit. On each trial it sets the bit under test on top of the bits it has already decided. It presents that code to an external DAC through `dacCode`, then reads the comparator answer on `cmpHigh` to decide whether the bit stays set.

Once the least significant bit is decided, the block loads the final code into a result register and raises a one-cycle done pulse. The DAC and the comparator sit outside the block. The number of clocks per conversion is fixed by the code width and does not depend on the input.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A start request seen while idle begins a conversion. In the next cycle `dacCode` holds only the most significant bit set, and every lower bit is zero.
- R2: Bits are tried one per cycle from the most significant to the least significant. During the trial of bit b, `dacCode` equals the bits above b as already decided, with bit b set to 1 and every bit below b at 0.
- R3: At the end of a trial cycle, `cmpHigh` = 1 keeps the tried bit at 1, and `cmpHigh` = 0 clears it to 0.
- R4: `busy` stays high for exactly N cycles for every input value. `donePulse` rises in the cycle after the last trial, at which point `busy` is low.
- R5: The result is the largest code whose comparator answer is high. With the comparator modelled as (code × step ≤ input), this is the floor of the input over the step. For example, an input of 108.5 steps gives 108 (8'b01101100).
- R6: A start request while `busy` is high is ignored. The running conversion keeps its length, its trial sequence and its result.
- R7: `donePulse` is high for a single cycle. `resultCode` changes only when a conversion completes, and it holds its value in every other cycle.
- R8: While reset (`rstN` low) is asserted and after it is released, `busy`, `donePulse`, `dacCode` and `resultCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a conversion |
| cmpHigh | input | 1 | Comparator answer: 1 when the DAC level is at or below the input |
| dacCode | output | N | Trial code driven to the external DAC |
| busy | output | 1 | High during the N trial cycles |
| donePulse | output | 1 | One-cycle pulse when the result is ready |
| resultCode | output | N | Final code of the last completed conversion |

## Verification
The bench models the comparator as a compare of the trial code against an input that carries two fraction bits below the LSB.

- **Zero and the all-ones limit:** these show whether every bit is cleared or every bit is kept.
- **Inputs just below and just above a power of two:** these separate an error in the MSB decision from an error in the lower bits.
- **Fractional inputs such as 108.5 steps:** these show whether the result rounds down to the step below.
- **Alternating-bit patterns:** on these, each trial is checked cycle by cycle against the expected search sequence, which exposes a wrong order or a wrong keep/clear polarity.

Directed cases follow the table:
- a second start request in the middle of a conversion;
- reset during a conversion;
- holding the result across idle cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes from the sequencer to the approximation register
  typedef struct packed {
    logic loadStart;   // begin conversion: register = MSB trial
    logic decide;      // a trial cycle is ending: keep or clear the bit
    logic lastStep;    // the trial ending is the LSB one
  } sarStrobes_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  output sar_pkg::sarStrobes_t strobes,
  output logic                 busy,
  output logic                 donePulse
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  logic          busyQ;
  logic [CW-1:0] bitCnt;
  logic          doneQ;

  always_comb begin
    strobes.loadStart = !busyQ && startReq;
    strobes.decide    = busyQ;
    strobes.lastStep  = busyQ && (bitCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobes.lastStep;
      if (strobes.loadStart) begin
        busyQ  <= 1'b1;
        bitCnt <= LAST_IDX;
      end else if (busyQ) begin
        if (bitCnt == '0) begin
          busyQ <= 1'b0;
        end else begin
          bitCnt <= bitCnt - CW'(1);
        end
      end
    end
  end

  assign busy      = busyQ;
  assign donePulse = doneQ;

  // Checker state: length of the current busy stretch
  logic [CW:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyLen <= '0;
    end else if (strobes.loadStart) begin
      busyLen <= '0;
    end else if (busyQ) begin
      busyLen <= busyLen + (CW+1)'(1);
    end
  end

  AST_FIXED_LEN: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (busyLen == (CW+1)'(N)) && !busyQ); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !strobes.lastStep) |=> busyQ && (bitCnt == $past(bitCnt) - CW'(1))); // R6

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sar_pkg::sarStrobes_t strobes,
  input  logic                 cmpHigh,
  output logic [N-1:0]         dacCode,
  output logic [N-1:0]         resultCode
);
  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] trialQ;
  logic [N-1:0] maskQ;
  logic [N-1:0] resultQ;
  logic [N-1:0] keptVal;
  logic [N-1:0] nextMask;

  // Per-bit keep/clear of the bit under test
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      keptVal[i] = trialQ[i] & (cmpHigh | ~maskQ[i]);
    end
  end

  assign nextMask = maskQ >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialQ  <= '0;
      maskQ   <= '0;
      resultQ <= '0;
    end else if (strobes.loadStart) begin
      trialQ <= MSB_ONLY;
      maskQ  <= MSB_ONLY;
    end else if (strobes.decide) begin
      trialQ <= keptVal | nextMask;
      maskQ  <= nextMask;
      if (strobes.lastStep) begin
        resultQ <= keptVal;
      end
    end
  end

  assign dacCode    = trialQ;
  assign resultCode = resultQ;

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStart |=> (trialQ == MSB_ONLY)); // R1
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decide |-> $onehot(maskQ)); // R2
  AST_KEEP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && !strobes.lastStep && cmpHigh) |=> ((trialQ & $past(maskQ)) != '0)); // R3
  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && !strobes.lastStep && !cmpHigh) |=> ((trialQ & $past(maskQ)) == '0)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lastStep |=> $stable(resultQ)); // R7

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         cmpHigh,
  output logic [N-1:0] dacCode,
  output logic         busy,
  output logic         donePulse,
  output logic [N-1:0] resultCode
);
  sar_pkg::sarStrobes_t strobes;

  sar_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .strobes   (strobes),
    .busy      (busy),
    .donePulse (donePulse)
  );

  sar_datapath #(.N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmpHigh    (cmpHigh),
    .dacCode    (dacCode),
    .resultCode (resultCode)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !busy && !donePulse && (resultCode == '0)); // R8

endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  localparam int N  = 8;
  localparam int FR = 2;          // fraction bits of the input stand-in
  localparam int NV = 10;
  localparam logic [N+FR-1:0] VEC [NV] = '{
    10'd0, 10'd3, 10'd4, 10'd434, 10'd1023,
    10'd1020, 10'd512, 10'd511, 10'd682, 10'd341
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpHigh;
  logic [N-1:0] dacCode;
  logic busy;
  logic donePulse;
  logic [N-1:0] resultCode;
  logic [N+FR-1:0] vin = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // Comparator stand-in: high while the DAC level is at or below the input
  assign cmpHigh = ({dacCode, {FR{1'b0}}} <= vin);

  sar_conv_ctrl #(.N(N)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cmpHigh    (cmpHigh),
    .dacCode    (dacCode),
    .busy       (busy),
    .donePulse  (donePulse),
    .resultCode (resultCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one conversion; midStart pulses a second request in the middle
  task automatic convert(input logic [N+FR-1:0] v, input bit midStart);
    logic [N-1:0] expCode;
    logic [N-1:0] expTrial;
    int trialErr;
    int doneAt;
    expCode = N'(v >> FR);
    vin = v;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check("R1 first trial", 32'(dacCode), 32'(1 << (N-1)));
    trialErr = 0;
    doneAt = -1;
    for (int i = 1; i <= N + 2; i++) begin
      if (i <= N) begin
        expTrial = (expCode & ~N'((1 << (N - i + 1)) - 1)) | N'(1 << (N - i));
        if (dacCode !== expTrial || !busy) trialErr++;
      end
      if (donePulse && doneAt < 0) doneAt = i;
      if (midStart && i == 3) startReq = 1'b1;
      if (midStart && i == 4) startReq = 1'b0;
      if (i == N + 1) begin
        check("R4 busy low at done", 32'(busy), 32'd0);
        check("R5 result", 32'(resultCode), 32'(expCode));
      end
      if (i == N + 2) check("R7 done single cycle", 32'(donePulse), 32'd0);
      @(negedge clk);
    end
    check("R2 R3 trial sequence", 32'(trialErr), 32'd0);
    check("R4 latency", 32'(doneAt), 32'(N + 1));
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    check("R8 reset busy", 32'(busy), 32'd0);
    check("R8 reset done", 32'(donePulse), 32'd0);
    check("R8 reset dac", 32'(dacCode), 32'd0);
    check("R8 reset result", 32'(resultCode), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", 32'(busy), 32'd0);

    for (int k = 0; k < NV; k++) begin
      convert(VEC[k], 1'b0);
    end

    // R5: 108.5 steps gives 8'b01101100
    convert(10'd434, 1'b0);
    check("R5 fractional example", 32'(resultCode), 32'h6C);

    // R6: second start in mid-conversion is ignored
    convert(10'd682, 1'b1);
    check("R6 no restart", 32'(busy), 32'd0);

    // R7: result holds across idle cycles with the input changed
    held = resultCode;
    vin = 10'd0;
    repeat (5) @(negedge clk);
    check("R7 result held", 32'(resultCode), 32'(held));

    // R8: reset during a conversion
    vin = 10'd700;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check("R8 reset mid busy", 32'(busy), 32'd0);
    check("R8 reset mid result", 32'(resultCode), 32'd0);
    rstN = 1'b1;
    convert(10'd700, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule